// File: doc/BRIEF.md
# Power-Fail Chip-Enable Supervisor

This block stands between a host's active-low chip-enable and four battery-backed low-power SRAM banks. While the supply is good, it passes the host enable through to one of four conditioned bank enables, picked by two select bits. The decode is combinational, so a select that changes in the same cycle as the enable falls still reaches the correct bank.

A synchronized power-fail flag (supply below the deselect threshold) puts the banks into write protection. New accesses are refused at once. An access that is already running may finish, but only until a bounded write-protect timeout runs out. After that the enables are forced inactive.

When the flag clears, two independent recovery timers start. One keeps the bank enables closed for a fixed interval, whatever the host enable does. The other holds an active-low reset to the host processor. A new power failure during recovery restarts both timers.

Top module: `pfce_supervisor`

## Requirements
- R1: While `host_ce_n` is high, all four bits of `bank_ce_n` are high.
- R2: In normal operation (power good, recovery complete), `host_ce_n` low drives exactly one `bank_ce_n` bit low, in the same cycle as the inputs with no clock edge between. The bit is chosen by `{sel_b,sel_a}`: 00 selects bit 0, 01 bit 1, 10 bit 2 and 11 bit 3.
- R3: If `pwr_fail` is high and no access is in progress, `bank_ce_n` is all ones in that same cycle. An enable that falls while `pwr_fail` is high is never passed on.
- R4: An access is in progress when `host_ce_n` was low and passed at the preceding rising edge. If `pwr_fail` rises during such an access, the access continues on the bank that was latched at that edge, and later select changes are ignored. Once `host_ce_n` returns high, no further access is passed.
- R5: Counting the first cycle in which `pwr_fail` is sampled high as fail cycle 0, every bank enable is high from fail cycle `WP_CYCLES` onward, even if `host_ce_n` is still low.
- R6: `por_n` is low from the rising edge that first samples `pwr_fail` high.
- R7: After `pwr_fail` falls, `bank_ce_n` stays all ones through `CE_REC_CYCLES` rising edges, counting from the first edge that samples the flag low. Normal decode resumes after edge number `CE_REC_CYCLES+1`.
- R8: After `pwr_fail` falls, `por_n` stays low through `RST_REC_CYCLES` rising edges and goes high after edge number `RST_REC_CYCLES+1`, with the same counting.
- R9: If `pwr_fail` rises during either recovery interval, both intervals restart in full from the next fall of the flag. The enables close again at once.
- R10: While `rst_n` is low, `bank_ce_n` is all ones and `por_n` is low. The block comes out of reset in the power-failed state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_ce_n | input | 1 | Host chip-enable, active low |
| sel_a | input | 1 | Bank select, low bit |
| sel_b | input | 1 | Bank select, high bit |
| pwr_fail | input | 1 | Synchronized flag: supply below the deselect threshold |
| bank_ce_n | output | 4 | Conditioned bank enables, active low |
| por_n | output | 1 | Reset to the host processor, active low |

## Verification
The decode and the refusal of new accesses are combinational, so the bench changes the inputs and samples the outputs one nanosecond later, with no clock edge in between. Protection, write-protect expiry and reset assertion take effect after rising edges. The bench drives `pwr_fail` at a falling edge and checks at each following falling edge. It counts rising edges to find the exact boundary: still closed after `CE_REC_CYCLES` or `RST_REC_CYCLES` edges and open after one more, or still passing after `WP_CYCLES-1` edges and forced high after `WP_CYCLES`. The checker uses its own counters of consecutive flag samples to bound the same windows at every edge.

// File: rtl/pfce_pkg.sv
package pfce_pkg;

    // Width of the bank select formed from {sel_b, sel_a}
    localparam int unsigned SEL_W = 2;

    // Supervisor operating modes
    typedef enum logic [1:0] {
        MODE_DOWN  = 2'd0,  // supply failed, banks protected
        MODE_DRAIN = 2'd1,  // supply failed, in-flight access allowed to finish
        MODE_UP    = 2'd2   // supply good (recovery timers may still run)
    } mode_e;

endpackage

// File: rtl/pfce_bank_decode.sv
module pfce_bank_decode #(
    parameter  int unsigned SEL_W     = 2,
    localparam int unsigned NUM_BANKS = 1 << SEL_W
) (
    input  logic                 enable,
    input  logic [SEL_W-1:0]     sel,
    output logic [NUM_BANKS-1:0] ce_n
);

    // One active-low output per bank; low only when enabled and selected
    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        assign ce_n[i] = ~(enable && (sel == SEL_W'(i)));
    end

endmodule

// File: rtl/pfce_interval_timer.sv
module pfce_interval_timer #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic done
);

    localparam int unsigned CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    // done rises on the LIMIT-th edge with restart low
    always_comb begin
        tmr_d = tmr_q;
        if (restart) begin
            tmr_d.cnt  = '0;
            tmr_d.done = 1'b0;
        end else if (!tmr_q.done) begin
            if (tmr_q.cnt == LAST) begin
                tmr_d.done = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign done = tmr_q.done;

endmodule

// File: rtl/pfce_supervisor.sv
module pfce_supervisor
    import pfce_pkg::*;
#(
    parameter int unsigned WP_CYCLES      = 30000,       // 150 us at 200 MHz
    parameter int unsigned CE_REC_CYCLES  = 16_000_000,  // 80 ms at 200 MHz
    parameter int unsigned RST_REC_CYCLES = 20_000_000   // 100 ms at 200 MHz
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_ce_n,
    input  logic       sel_a,
    input  logic       sel_b,
    input  logic       pwr_fail,
    output logic [3:0] bank_ce_n,
    output logic       por_n
);

    // Drain timer fires one edge short of the limit: fail cycle 0 is spent in MODE_UP
    localparam int unsigned WP_LIMIT  = (WP_CYCLES > 2) ? WP_CYCLES - 1 : 1;
    localparam int unsigned CE_LIMIT  = (CE_REC_CYCLES  > 0) ? CE_REC_CYCLES  : 1;
    localparam int unsigned RST_LIMIT = (RST_REC_CYCLES > 0) ? RST_REC_CYCLES : 1;

    typedef struct packed {
        mode_e            mode;
        logic             active;  // an access passed at the last edge
        logic [SEL_W-1:0] bank;    // bank of that access
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic [SEL_W-1:0] sel_in;
    logic             dec_en;
    logic [SEL_W-1:0] dec_sel;
    logic             ce_open;
    logic             wp_expired;
    logic             rec_restart;
    logic             wp_restart;

    assign sel_in      = {sel_b, sel_a};
    assign rec_restart = (ctl_q.mode != MODE_UP) || pwr_fail;
    assign wp_restart  = (ctl_q.mode != MODE_DRAIN);

    // Next-state and decode-enable logic
    always_comb begin
        ctl_d   = ctl_q;
        dec_en  = 1'b0;
        dec_sel = sel_in;
        unique case (ctl_q.mode)
            MODE_UP: begin
                if (!pwr_fail) begin
                    dec_en       = ce_open && !host_ce_n;
                    dec_sel      = sel_in;
                    ctl_d.active = ce_open && !host_ce_n;
                    ctl_d.bank   = sel_in;
                end else begin
                    // only an access already under way may continue
                    dec_en       = ce_open && ctl_q.active && !host_ce_n;
                    dec_sel      = ctl_q.bank;
                    ctl_d.active = 1'b0;
                    ctl_d.mode   = (ce_open && ctl_q.active && !host_ce_n)
                                   ? MODE_DRAIN : MODE_DOWN;
                end
            end
            MODE_DRAIN: begin
                dec_en       = !host_ce_n && !wp_expired;
                dec_sel      = ctl_q.bank;
                ctl_d.active = 1'b0;
                if (host_ce_n || wp_expired) begin
                    ctl_d.mode = MODE_DOWN;
                end
            end
            MODE_DOWN: begin
                ctl_d.active = 1'b0;
                if (!pwr_fail) begin
                    ctl_d.mode = MODE_UP;
                end
            end
            default: begin
                ctl_d.mode   = MODE_DOWN;
                ctl_d.active = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.mode   <= MODE_DOWN;
            ctl_q.active <= 1'b0;
            ctl_q.bank   <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Enable recovery interval
    pfce_interval_timer #(.LIMIT(CE_LIMIT)) u_ce_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (rec_restart),
        .done    (ce_open)
    );

    // Processor reset recovery interval
    pfce_interval_timer #(.LIMIT(RST_LIMIT)) u_rst_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (rec_restart),
        .done    (por_n)
    );

    // Write-protect timeout for a draining access
    pfce_interval_timer #(.LIMIT(WP_LIMIT)) u_wp_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wp_restart),
        .done    (wp_expired)
    );

    pfce_bank_decode #(.SEL_W(SEL_W)) u_decode (
        .enable (dec_en),
        .sel    (dec_sel),
        .ce_n   (bank_ce_n)
    );

endmodule

// File: rtl/pfce_supervisor_chk.sv
module pfce_supervisor_chk #(
    parameter int unsigned WP_CYCLES      = 30000,
    parameter int unsigned CE_REC_CYCLES  = 16_000_000,
    parameter int unsigned RST_REC_CYCLES = 20_000_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       host_ce_n,
    input logic       sel_a,
    input logic       sel_b,
    input logic       pwr_fail,
    input logic [3:0] bank_ce_n,
    input logic       por_n
);

    localparam int unsigned SAT = WP_CYCLES + CE_REC_CYCLES + RST_REC_CYCLES + 8;
    localparam int unsigned CW  = $clog2(SAT + 1);
    localparam logic [CW-1:0] SAT_V    = CW'(SAT);
    localparam logic [CW-1:0] WP_V     = CW'(WP_CYCLES);
    localparam logic [CW-1:0] RST_V    = CW'(RST_REC_CYCLES);
    localparam logic [CW-1:0] SETTLE_V = CW'(CE_REC_CYCLES + WP_CYCLES + 2);

    // consecutive prior edges with the flag high / low
    logic [CW-1:0] fail_run_q, good_run_q;
    logic [3:0]    exp_ce_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_run_q <= '0;
            good_run_q <= '0;
        end else begin
            fail_run_q <= !pwr_fail ? '0 : ((fail_run_q == SAT_V) ? SAT_V : fail_run_q + 1'b1);
            good_run_q <=  pwr_fail ? '0 : ((good_run_q == SAT_V) ? SAT_V : good_run_q + 1'b1);
        end
    end

    always_comb begin
        exp_ce_n = host_ce_n ? 4'hF : ~(4'b0001 << {sel_b, sel_a});
    end

    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        host_ce_n |-> (bank_ce_n == 4'hF));

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bank_ce_n));

    p_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_fail && good_run_q > SETTLE_V) |-> (bank_ce_n == exp_ce_n));

    p_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_fail && host_ce_n) |=> (bank_ce_n == 4'hF));

    p_wp_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_fail && fail_run_q >= WP_V) |-> (bank_ce_n == 4'hF));

    p_por_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> !por_n);

    p_por_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (good_run_q <= RST_V) |-> !por_n);

endmodule

bind pfce_supervisor pfce_supervisor_chk #(
    .WP_CYCLES      (WP_CYCLES),
    .CE_REC_CYCLES  (CE_REC_CYCLES),
    .RST_REC_CYCLES (RST_REC_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_ce_n (host_ce_n),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .pwr_fail  (pwr_fail),
    .bank_ce_n (bank_ce_n),
    .por_n     (por_n)
);

// File: tb/pfce_supervisor_test.sv
`timescale 1ns/1ps
module pfce_supervisor_test;

    localparam int WP  = 6;
    localparam int CER = 10;
    localparam int RSR = 14;
    localparam int MAXREC = (CER > RSR) ? CER : RSR;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       host_ce_n;
    logic       sel_a, sel_b;
    logic       pwr_fail;
    logic [3:0] bank_ce_n;
    logic       por_n;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pfce_supervisor #(
        .WP_CYCLES(WP), .CE_REC_CYCLES(CER), .RST_REC_CYCLES(RSR)
    ) uut (
        .clk(clk), .rst_n(rst_n), .host_ce_n(host_ce_n), .sel_a(sel_a),
        .sel_b(sel_b), .pwr_fail(pwr_fail), .bank_ce_n(bank_ce_n), .por_n(por_n)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic next_cycle();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    // pwr_fail must have been lowered at the preceding negedge; host low, select 0
    task automatic recover_check(input string ce_tag, input string rst_tag);
        for (int k = 1; k <= MAXREC + 2; k++) begin
            next_cycle();
            chk(ce_tag,  bank_ce_n, (k >= CER + 1) ? 4'b1110 : 4'hF);
            chk(rst_tag, {3'b0, por_n}, {3'b0, (k >= RSR + 1)});
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired, actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pwr_fail = 1'b0; host_ce_n = 1'b0; sel_a = 1'b0; sel_b = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk("R10 reset enables", bank_ce_n, 4'hF);
        chk("R10 reset por", {3'b0, por_n}, 4'h0);

        // power-up recovery with host enable held low
        @(negedge clk) rst_n = 1'b1;
        recover_check("R7", "R8");

        // full decode sweep, zero setup
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            host_ce_n = v[2]; sel_b = v[1]; sel_a = v[0];
            #1;
            if (v[2]) chk("R1 idle", bank_ce_n, 4'hF);
            else      chk("R2 decode", bank_ce_n, ~(4'b0001 << v[1:0]));
        end

        // failure with no access in progress
        @(negedge clk);
        host_ce_n = 1'b1; pwr_fail = 1'b1;
        #1 chk("R3 idle at fail", bank_ce_n, 4'hF);
        next_cycle();
        chk("R6 por low", {3'b0, por_n}, 4'h0);
        host_ce_n = 1'b0; sel_b = 1'b1; sel_a = 1'b0;
        #1 chk("R3 new access blocked", bank_ce_n, 4'hF);
        repeat (3) begin
            next_cycle();
            chk("R3 still blocked", bank_ce_n, 4'hF);
        end
        @(negedge clk);
        pwr_fail = 1'b0; sel_b = 1'b0; sel_a = 1'b0;
        recover_check("R7", "R8");

        // failure during a short access on bank 2
        @(negedge clk);
        sel_b = 1'b1; sel_a = 1'b0;
        @(negedge clk);
        pwr_fail = 1'b1;
        #1 chk("R4 access continues", bank_ce_n, 4'b1011);
        @(negedge clk);
        sel_b = 1'b0; sel_a = 1'b1;
        #1 chk("R4 select ignored", bank_ce_n, 4'b1011);
        chk("R6 por low in drain", {3'b0, por_n}, 4'h0);
        next_cycle();
        chk("R4 still draining", bank_ce_n, 4'b1011);
        host_ce_n = 1'b1;
        #1 chk("R4 access ended", bank_ce_n, 4'hF);
        @(negedge clk);
        host_ce_n = 1'b0;
        #1 chk("R4 no new access", bank_ce_n, 4'hF);
        repeat (2) next_cycle();
        chk("R4 no new access later", bank_ce_n, 4'hF);
        @(negedge clk);
        pwr_fail = 1'b0; sel_b = 1'b0; sel_a = 1'b0;
        recover_check("R7", "R8");

        // failure during a long access on bank 3: forced high at fail cycle WP
        @(negedge clk);
        sel_b = 1'b1; sel_a = 1'b1;
        @(negedge clk);
        pwr_fail = 1'b1;
        #1 chk("R5 fail cycle 0", bank_ce_n, 4'b0111);
        for (int j = 1; j <= WP + 1; j++) begin
            next_cycle();
            chk("R5 timeout", bank_ce_n, (j < WP) ? 4'b0111 : 4'hF);
        end
        @(negedge clk);
        pwr_fail = 1'b0; sel_b = 1'b0; sel_a = 1'b0;
        recover_check("R7", "R8");

        // re-failure during recovery restarts both intervals
        @(negedge clk);
        host_ce_n = 1'b1;
        @(negedge clk);
        pwr_fail = 1'b1;
        @(negedge clk);
        pwr_fail = 1'b0; host_ce_n = 1'b0;
        repeat (4) begin
            next_cycle();
            chk("R7 recovering", bank_ce_n, 4'hF);
        end
        @(negedge clk);
        pwr_fail = 1'b1;
        #1 chk("R9 closed at re-fail", bank_ce_n, 4'hF);
        @(negedge clk);
        pwr_fail = 1'b0;
        recover_check("R9 enables", "R9 reset");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule